// File: doc/BRIEF.md
# Matrix Keypad Column Scanner

This block scans a sixteen-key matrix wired to an eight-bit port. The upper four port bits are column drives and the lower four are row senses. The scanner pulls exactly one column low at a time and steps the low column downward, one position per scan-rate tick. On each tick it compares the byte read back from the port with the byte it is driving. A mismatch means a key closes a column onto a row. The whole read-back byte then becomes the scan code for that scan, and the scan ends early.

A key is reported only when two scans in a row end with the same scan code, and only when the scanner has been re-armed by a scan that found nothing. A reported code goes through a fixed sixteen-entry table to a hexadecimal key value. A code that is not in the table is flagged as invalid and carries the value 0xFF. After a report the column drive stays parked on the column where the key was found until that key lets go.

The key output is a one-cycle strobe with no back-pressure. There is no ready input, so the consumer must capture `key_value` in the cycle in which `key_valid` or `key_invalid` is high. The value stays on `key_value` until the next report.

Top module: `keypad_scanner`

## Requirements
- R1: The drive byte holds its low nibble at all ones and has exactly one zero in its high nibble. After reset the zero is in bit 7. Each tick with no detection moves the zero one bit lower (0x7F, 0xBF, 0xDF, 0xEF), and from 0xEF it wraps back to 0x7F.
- R2: The drive byte changes only in the cycle after a cycle in which `scan_tick` is high.
- R3: On a tick, a read-back byte that differs from the drive byte is a detection, and that byte is the scan code. If no report follows, the next scan starts again at 0x7F.
- R4: A report happens only when the current scan and the scan just before it both ended in a detection with the same scan code.
- R5: A reported code maps as follows: ED→1, 7E→2, 7D→3, 7B→A, BE→4, BD→5, BB→6, DE→B, DD→7, DB→8, 77→9, B7→E, EE→C, D7→0, EB→D, E7→F. `key_valid` pulses in the cycle after the reporting tick, and `key_value` carries the mapped value from that cycle on.
- R6: A reported code that is not in the R5 table pulses `key_invalid` instead, and sets `key_value` to 0xFF.
- R7: After a report the drive byte stays parked while the read-back still differs from it. No further report is made while parked. When the read-back on a tick matches the parked drive, scanning resumes at 0x7F.
- R8: After reset, and after every report, no report is made until one complete scan of four ticks has found no detection.
- R9: Reset is asynchronous and active low. During reset the drive byte is 0x7F, `key_value` is 0xFF and both strobes are low.
- R10: `key_valid` and `key_invalid` are never high together, and each is high for at most one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_tick | input | 1 | Scan-rate enable; one step per high cycle |
| port_in | input | 8 | Port read-back: columns in [7:4], rows in [3:0] |
| drive_out | output | 8 | Port drive byte with a walking zero in [7:4] |
| key_value | output | 8 | Last reported key value, or 0xFF when unmatched |
| key_valid | output | 1 | One-cycle strobe for a matched key |
| key_invalid | output | 1 | One-cycle strobe for an unmatched scan code |

## Verification
The bench drives all sixteen single-key presses, each held and then released. Together these separate a table-mapping fault from a column-step fault, because every column and every row is hit. Two keys pressed in one column give an off-table code, which proves the invalid path. A short press on one key followed straight away by a different key checks that the debounce compares codes and does not just count detections. Moving a held key to another column with no release in between checks that reporting waits for an empty scan and does not restart on any change.

// File: rtl/keypad_scanner_pkg.sv
package keypad_scanner_pkg;
  localparam int NCOL   = 4;
  localparam int PORT_W = 2 * NCOL;
  localparam int STEP_W = $clog2(NCOL);
  localparam logic [7:0] NO_KEY = 8'hFF;

  function automatic logic [7:0] code_to_key(input logic [7:0] code);
    logic [7:0] v;
    case (code)
      8'hD7: v = 8'h00;
      8'hED: v = 8'h01;
      8'h7E: v = 8'h02;
      8'h7D: v = 8'h03;
      8'hBE: v = 8'h04;
      8'hBD: v = 8'h05;
      8'hBB: v = 8'h06;
      8'hDD: v = 8'h07;
      8'hDB: v = 8'h08;
      8'h77: v = 8'h09;
      8'h7B: v = 8'h0A;
      8'hDE: v = 8'h0B;
      8'hEE: v = 8'h0C;
      8'hEB: v = 8'h0D;
      8'hB7: v = 8'h0E;
      8'hE7: v = 8'h0F;
      default: v = NO_KEY;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/keypad_col_walker.sv
module keypad_col_walker #(
  parameter int NCOL = 4,
  localparam int PW = 2 * NCOL,
  localparam int SW = (NCOL > 1) ? $clog2(NCOL) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          hit,
  input  logic          report,
  output logic [PW-1:0] drive,
  output logic          scan_key,
  output logic          scan_empty
);
  logic [SW-1:0] step;
  logic          held;
  logic          last;

  assign last       = (step == SW'(NCOL - 1));
  assign scan_key   = tick & ~held & hit;
  assign scan_empty = tick & ~held & ~hit & last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step <= '0;
      held <= 1'b0;
    end else if (tick) begin
      if (held) begin
        if (!hit) begin
          held <= 1'b0;
          step <= '0;
        end
      end else if (hit) begin
        if (report) held <= 1'b1;
        else        step <= '0;
      end else if (last) begin
        step <= '0;
      end else begin
        step <= step + SW'(1);
      end
    end
  end

  for (genvar i = 0; i < NCOL; i++) begin : g_col
    assign drive[PW-1-i] = (step != SW'(i));
    assign drive[i]      = 1'b1;
  end

  assert_one_col_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(drive[PW-1 -: NCOL]) == NCOL - 1) && (&drive[NCOL-1:0]));

  assert_tick_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(drive));

  assert_parked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && report) |=> $stable(drive));
endmodule

// File: rtl/keypad_debounce.sv
module keypad_debounce #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scan_key,
  input  logic          scan_empty,
  input  logic [PW-1:0] code,
  output logic          report
);
  logic          armed;
  logic          have_prev;
  logic [PW-1:0] prev_code;

  assign report = scan_key & armed & have_prev & (prev_code == code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      have_prev <= 1'b0;
      prev_code <= '1;
    end else if (scan_key) begin
      have_prev <= 1'b1;
      prev_code <= code;
      if (report) armed <= 1'b0;
    end else if (scan_empty) begin
      armed     <= 1'b1;
      have_prev <= 1'b0;
    end
  end

  assert_rearm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    report |=> !report);
endmodule

// File: rtl/keypad_code_map.sv
module keypad_code_map
  import keypad_scanner_pkg::*;
(
  input  logic [7:0] code,
  output logic [7:0] value,
  output logic       miss
);
  assign value = code_to_key(code);
  assign miss  = (value == NO_KEY);
endmodule

// File: rtl/keypad_scanner.sv
module keypad_scanner
  import keypad_scanner_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scan_tick,
  input  logic [7:0] port_in,
  output logic [7:0] drive_out,
  output logic [7:0] key_value,
  output logic       key_valid,
  output logic       key_invalid
);
  logic       hit;
  logic       report;
  logic       scan_key;
  logic       scan_empty;
  logic [7:0] mapped;
  logic       miss;

  assign hit = (port_in != drive_out);

  keypad_col_walker #(.NCOL(NCOL)) u_walker (
    .clk(clk), .rst_n(rst_n), .tick(scan_tick), .hit(hit), .report(report),
    .drive(drive_out), .scan_key(scan_key), .scan_empty(scan_empty)
  );

  keypad_debounce #(.PW(PORT_W)) u_debounce (
    .clk(clk), .rst_n(rst_n), .scan_key(scan_key), .scan_empty(scan_empty),
    .code(port_in), .report(report)
  );

  keypad_code_map u_map (.code(port_in), .value(mapped), .miss(miss));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_value   <= NO_KEY;
      key_valid   <= 1'b0;
      key_invalid <= 1'b0;
    end else begin
      key_valid   <= report & ~miss;
      key_invalid <= report & miss;
      if (report) key_value <= mapped;
    end
  end

  assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(key_valid && key_invalid));

  assert_strobe_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid || key_invalid) |=> !(key_valid || key_invalid));

  assert_invalid_ff_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_invalid |-> key_value == NO_KEY);

  assert_valid_hex_R5: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> key_value < 8'h10);

  assert_report_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid || key_invalid) |-> $past(scan_tick && hit));
endmodule

// File: tb/keypad_scanner_test.sv
`timescale 1ns/1ps
module keypad_scanner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_tick = 1'b0;
  logic [7:0] port_in;
  logic [7:0] drive_out;
  logic [7:0] key_value;
  logic       key_valid;
  logic       key_invalid;

  logic       pressed = 1'b0;
  logic [7:0] pcode = 8'hFF;

  int n_cmp = 0;
  int n_bad = 0;
  int tick_cnt = 0;

  always #2.5 clk = ~clk;

  keypad_scanner uut (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .port_in(port_in),
    .drive_out(drive_out), .key_value(key_value), .key_valid(key_valid),
    .key_invalid(key_invalid)
  );

  // Keypad: a pressed key pulls its rows low while its column is driven low.
  assign port_in = (pressed && drive_out[7:4] == pcode[7:4]) ?
                   {drive_out[7:4], pcode[3:0]} : drive_out;

  // Key table for R5, held as plain arrays.
  logic [7:0] tcode [16];
  logic [7:0] tval  [16];
  initial begin
    tcode[0]=8'hED; tval[0]=8'h1;  tcode[1]=8'h7E; tval[1]=8'h2;
    tcode[2]=8'h7D; tval[2]=8'h3;  tcode[3]=8'h7B; tval[3]=8'hA;
    tcode[4]=8'hBE; tval[4]=8'h4;  tcode[5]=8'hBD; tval[5]=8'h5;
    tcode[6]=8'hBB; tval[6]=8'h6;  tcode[7]=8'hDE; tval[7]=8'hB;
    tcode[8]=8'hDD; tval[8]=8'h7;  tcode[9]=8'hDB; tval[9]=8'h8;
    tcode[10]=8'h77; tval[10]=8'h9; tcode[11]=8'hB7; tval[11]=8'hE;
    tcode[12]=8'hEE; tval[12]=8'hC; tcode[13]=8'hD7; tval[13]=8'h0;
    tcode[14]=8'hEB; tval[14]=8'hD; tcode[15]=8'hE7; tval[15]=8'hF;
  end

  // Behavioural reference model
  int         m_col = 0;
  bit         m_park = 0, m_armed = 0, m_have = 0;
  logic [7:0] m_prev = 8'hFF, m_val = 8'hFF;
  bit         m_vld = 0, m_inv = 0;

  function automatic logic [7:0] m_drive(int col);
    return 8'hFF ^ (8'h80 >> col);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_col = 0; m_park = 0; m_armed = 0; m_have = 0;
      m_prev = 8'hFF; m_val = 8'hFF; m_vld = 0; m_inv = 0;
    end else begin
      m_vld = 0; m_inv = 0;
      if (scan_tick) begin
        if (m_park) begin
          if (port_in == m_drive(m_col)) begin m_park = 0; m_col = 0; end
        end else if (port_in != m_drive(m_col)) begin
          if (m_armed && m_have && m_prev == port_in) begin
            m_val = 8'hFF;
            for (int k = 0; k < 16; k++) if (tcode[k] == port_in) m_val = tval[k];
            if (m_val == 8'hFF) m_inv = 1; else m_vld = 1;
            m_armed = 0; m_park = 1;
          end else begin
            m_col = 0;
          end
          m_have = 1; m_prev = port_in;
        end else if (m_col == 3) begin
          m_col = 0; m_armed = 1; m_have = 0;
        end else begin
          m_col++;
        end
      end
    end
  end

  task automatic compare();
    n_cmp++;
    if (drive_out !== m_drive(m_col)) begin
      n_bad++;
      $display("FAIL R1 R2 R3 R7 R9 drive_out actual=%h expected=%h t=%0t", drive_out, m_drive(m_col), $time);
    end
    n_cmp++;
    if (key_valid !== m_vld) begin
      n_bad++;
      $display("FAIL R4 R5 R8 R10 key_valid actual=%b expected=%b t=%0t", key_valid, m_vld, $time);
    end
    n_cmp++;
    if (key_invalid !== m_inv) begin
      n_bad++;
      $display("FAIL R6 R10 key_invalid actual=%b expected=%b t=%0t", key_invalid, m_inv, $time);
    end
    n_cmp++;
    if (key_value !== m_val) begin
      n_bad++;
      $display("FAIL R5 R6 key_value actual=%h expected=%h t=%0t", key_value, m_val, $time);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      tick_cnt = (tick_cnt + 1) % 3;
      scan_tick = (tick_cnt == 0);
    end
  endtask

  task automatic press(logic [7:0] code, int n);
    pressed = 1'b1; pcode = code;
    run(n);
  endtask

  task automatic release_key(int n);
    pressed = 1'b0;
    run(n);
  endtask

  initial begin
    // R9: reset values
    run(4);
    rst_n = 1'b1;
    // R1 R2: idle walking pattern, also arms the scanner (R8)
    run(30);
    // R5 R7 R8: every key held, then released
    for (int k = 0; k < 16; k++) begin
      press(tcode[k], 45);
      release_key(40);
    end
    // R6: two rows in one column give an off-table code
    press(8'h7C, 45);
    release_key(40);
    // R4: brief bounce on one key, then a different key
    press(8'hBE, 4);
    press(8'hDD, 45);
    release_key(40);
    // R8: held key moves to another column with no empty scan between
    press(8'h7E, 45);
    press(8'hE7, 60);
    release_key(40);
    // R3: press right after reset with no empty scan yet
    rst_n = 1'b0;
    press(8'hBB, 4);
    rst_n = 1'b1;
    run(45);
    release_key(40);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule